// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policies

A single-level, direct-mapped cache controller that sits between a processor port and a word-wide main-memory port. Each line holds one data word together with a tag, a valid flag and a modified flag. The address splits into a low index field, which selects the line, and a high tag field, which is compared against the stored tag. Loads and stores that hit complete in the cycle they are presented. Misses stall the processor while the controller talks to memory one access at a time.

Two parameters select the write behaviour. `WRITE_BACK` chooses between updating memory on every store (0) and holding modified data in the line until it is evicted (1). `WRITE_ALLOC` chooses whether a store that misses installs its data in the line (1) or only goes to memory (0). When a line that holds modified data must give way to a new address, its old contents are first written to memory at the address formed from the stored tag and the index. Only after that is the new word read.

The processor holds `req_i`, `we_i`, `addr_i` and `wdata_i` stable until it sees `ready_o` high at a rising edge. For loads, `rdata_o` is valid in that same cycle. The memory port holds its request stable until `mem_ack_i` arrives. Read data is taken from `mem_rdata_i` in the acknowledge cycle.

Top module: `dm_cache`

## Requirements
- R1: A request hits when the line chosen by `addr_i[IDX_W-1:0]` is valid and its stored tag equals `addr_i[ADDR_W-1:IDX_W]`. A load hit raises `ready_o` in its first cycle, returns the line's word on `rdata_o` and causes no memory access.
- R2: After reset every line is invalid and clean, so the first load to any address misses and reads memory.
- R3: With `WRITE_BACK`=0, a store hit updates the line and makes exactly one memory write of the same address and data. No write to any other address is ever made in this mode.
- R4: With `WRITE_BACK`=1, a store hit completes in one cycle, updates only the line, marks it modified and makes no memory access.
- R5: When a load miss, or an allocating store miss, finds the line valid and modified, the old word is written to memory at {stored tag, index}. This write completes before any read for the new address is issued.
- R6: A load miss that finds the line invalid or unmodified makes no memory write and exactly one memory read.
- R7: With `WRITE_ALLOC`=0, a store miss makes exactly one memory write of the store. The line's tag, valid flag and data stay unchanged, so a later load of the previous occupant still hits.
- R8: With `WRITE_ALLOC`=1, a store miss installs the store data without any memory read, and a later load to that address hits. In `WRITE_BACK`=1 mode the line is left modified, and the store completes in one cycle unless an eviction is needed first.
- R9: `ready_o` is low in every cycle that `mem_req_o` is high. Any request that needs memory therefore takes more than one cycle.
- R10: Once raised, `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold until `mem_ack_i`. Memory traffic occurs only while `req_i` is high.
- R11: A load miss returns the word read from memory, and the line is left unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Processor request, held until accepted |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Store data |
| ready_o | output | 1 | Request completes at this rising edge |
| rdata_o | output | DATA_W | Load data, valid with `ready_o` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory access completes |
| mem_rdata_i | input | DATA_W | Memory read data, valid with `mem_ack_i` |

## Verification
Two activities can fall into one request: evicting a modified victim and filling the same line for a new address. Either a load or an allocating store can trigger this.

The bench provokes it by drawing addresses from a small pool in which three tags share each of four lines, with stores mixed in. The case therefore recurs many times in each of the four policy combinations.

A behavioural reference model predicts, for every request, how many memory writes and reads occur, whether completion takes one cycle, and the returned word. After each request the bench compares the whole memory image against the predicted one, which shows that the victim landed at {old tag, index} with its modified value. Checker properties also confirm that a victim write shares the request's index and that no read ever serves a store.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_REFILL,
    ST_STORE,
    ST_RESP
  } cache_st_e;
endpackage

// File: rtl/dm_cache_lines.sv
module dm_cache_lines #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic              wr_dirty_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_dirty_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_vec;
  logic [LINES-1:0]  dirty_vec;
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [DATA_W-1:0] data_arr [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              sel;
    logic              v_q, d_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] w_q;

    assign sel = (idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (wr_en_i && sel) begin
        v_q <= 1'b1;
        d_q <= wr_dirty_i;
      end else if (clr_dirty_i && sel) begin
        d_q <= 1'b0;
      end
    end

    // payload needs no reset: guarded by v_q
    always_ff @(posedge clk_i) begin
      if (wr_en_i && sel) begin
        t_q <= wr_tag_i;
        w_q <= wr_data_i;
      end
    end

    assign valid_vec[i] = v_q;
    assign dirty_vec[i] = d_q;
    assign tag_arr[i]   = t_q;
    assign data_arr[i]  = w_q;
  end

  assign valid_o = valid_vec[idx_i];
  assign dirty_o = dirty_vec[idx_i];
  assign tag_o   = tag_arr[idx_i];
  assign data_o  = data_arr[idx_i];
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int IDX_W       = 3,
  parameter int DATA_W      = 16,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    line_valid_i,
  input  logic                    line_dirty_i,
  input  logic [ADDR_W-IDX_W-1:0] line_tag_i,
  input  logic [DATA_W-1:0]       line_data_i,
  input  logic                    mem_ack_i,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic                    ready_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  output logic                    wr_en_o,
  output logic                    wr_dirty_o,
  output logic [DATA_W-1:0]       wr_data_o,
  output logic                    clr_dirty_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  cache_st_e state_q, state_d;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic             hit, victim_dirty;

  assign req_tag      = addr_i[ADDR_W-1:IDX_W];
  assign req_idx      = addr_i[IDX_W-1:0];
  assign hit          = line_valid_i && (line_tag_i == req_tag);
  assign victim_dirty = WRITE_BACK && line_valid_i && line_dirty_i && !hit;

  always_comb begin
    state_d     = state_q;
    ready_o     = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_i;
    mem_wdata_o = wdata_i;
    wr_en_o     = 1'b0;
    wr_dirty_o  = 1'b0;
    wr_data_o   = wdata_i;
    clr_dirty_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (!we_i) begin
            if (hit) ready_o = 1'b1;
            else     state_d = victim_dirty ? ST_EVICT : ST_REFILL;
          end else if (hit) begin
            if (WRITE_BACK) begin
              wr_en_o    = 1'b1;
              wr_dirty_o = 1'b1;
              ready_o    = 1'b1;
            end else begin
              state_d = ST_STORE;
            end
          end else if (WRITE_ALLOC && WRITE_BACK) begin
            if (victim_dirty) begin
              state_d = ST_EVICT;
            end else begin
              // one-word line: install straight from store data
              wr_en_o    = 1'b1;
              wr_dirty_o = 1'b1;
              ready_o    = 1'b1;
            end
          end else begin
            state_d = ST_STORE;
          end
        end
      end
      ST_EVICT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {line_tag_i, req_idx};
        mem_wdata_o = line_data_i;
        if (mem_ack_i) begin
          clr_dirty_o = 1'b1;
          state_d     = ST_IDLE; // re-evaluate: line is now clean
        end
      end
      ST_REFILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          wr_en_o   = 1'b1;
          wr_data_o = mem_rdata_i;
          state_d   = ST_IDLE;   // replays as a hit
        end
      end
      ST_STORE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) begin
          wr_en_o = hit || WRITE_ALLOC;
          state_d = ST_RESP;
        end
      end
      ST_RESP: begin
        ready_o = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W      = 6,
  parameter int IDX_W       = 3,
  parameter int DATA_W      = 16,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              wr_en, wr_dirty, clr_dirty;
  logic [DATA_W-1:0] wr_data;

  dm_cache_lines #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_lines (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (addr_i[IDX_W-1:0]),
    .wr_en_i    (wr_en),
    .wr_dirty_i (wr_dirty),
    .wr_tag_i   (addr_i[ADDR_W-1:IDX_W]),
    .wr_data_i  (wr_data),
    .clr_dirty_i(clr_dirty),
    .valid_o    (line_valid),
    .dirty_o    (line_dirty),
    .tag_o      (line_tag),
    .data_o     (line_data)
  );

  dm_cache_ctrl #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .DATA_W     (DATA_W),
    .WRITE_BACK (WRITE_BACK),
    .WRITE_ALLOC(WRITE_ALLOC)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .line_valid_i(line_valid),
    .line_dirty_i(line_dirty),
    .line_tag_i  (line_tag),
    .line_data_i (line_data),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .ready_o     (ready_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .wr_en_o     (wr_en),
    .wr_dirty_o  (wr_dirty),
    .wr_data_o   (wr_data),
    .clr_dirty_o (clr_dirty)
  );

  assign rdata_o = line_data;
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int ADDR_W      = 6,
  parameter int IDX_W       = 3,
  parameter int DATA_W      = 16,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  AST_NO_READY_DURING_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o); // R9

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R10

  AST_MEM_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> req_i); // R10

  AST_VICTIM_SAME_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && (mem_addr_o != addr_i)
      |-> WRITE_BACK && (mem_addr_o[IDX_W-1:0] == addr_i[IDX_W-1:0])); // R5

  AST_WT_OWN_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !WRITE_BACK && mem_req_o |-> mem_addr_o == addr_i); // R3

  AST_NO_READ_FOR_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> !we_i); // R8

  AST_NA_STORE_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !WRITE_ALLOC && mem_req_o && we_i |-> mem_we_o); // R7
endmodule

bind dm_cache dm_cache_chk #(
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W),
  .DATA_W     (DATA_W),
  .WRITE_BACK (WRITE_BACK),
  .WRITE_ALLOC(WRITE_ALLOC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .ready_o    (ready_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i)
);

// File: tb/dm_cache_lane.sv
module dm_cache_lane #(
  parameter bit WB = 1'b1,
  parameter bit WA = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_err,
  output bit   done
);
  localparam int AW = 6, IW = 3, DW = 16, LN = 8, WORDS = 64;

  logic          req, we, ready;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  dm_cache #(
    .ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .WRITE_BACK(WB), .WRITE_ALLOC(WA)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model: acks after three cycles of request
  int mem [WORDS];
  int n_wr, n_rd, wait_cnt;
  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = (i * 37 + 11) & 16'hffff;
    n_wr = 0; n_rd = 0; wait_cnt = 0; mem_ack = 1'b0; mem_rdata = '0;
  end
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt == 2) begin
        mem_ack  <= 1'b1;
        wait_cnt <= 0;
        if (mem_we) begin
          mem[int'(mem_addr)] <= int'(mem_wdata);
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata <= DW'(mem[int'(mem_addr)]);
          n_rd <= n_rd + 1;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // reference model
  bit rv [LN];
  bit rd [LN];
  int rt [LN];
  int rdat [LN];
  int rmem [WORDS];

  task automatic chk(input bit ok, input string rq, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s lane wb=%0d wa=%0d: actual %0d expected %0d", rq, WB, WA, act, exp_v);
    end
  endtask

  task automatic access(input bit st, input int a, input int d);
    int idx = a % LN;
    int tg  = a / LN;
    bit hit = rv[idx] && (rt[idx] == tg);
    bit vd  = WB && rv[idx] && rd[idx] && !hit;
    int ewr = 0, erd = 0, edat = 0, cyc, wr0, rd0, got, mism;
    bit one = 0;
    string tag_s;
    if (!st) begin
      if (hit) begin
        one = 1; edat = rdat[idx]; tag_s = "R1";
      end else begin
        if (vd) begin
          rmem[rt[idx] * LN + idx] = rdat[idx]; ewr = 1; tag_s = "R5";
        end else tag_s = "R6";
        erd = 1; edat = rmem[a];
        rv[idx] = 1; rd[idx] = 0; rt[idx] = tg; rdat[idx] = edat;
      end
    end else if (hit) begin
      rdat[idx] = d;
      if (WB) begin rd[idx] = 1; one = 1; tag_s = "R4"; end
      else begin rmem[a] = d; ewr = 1; tag_s = "R3"; end
    end else if (WA) begin
      if (vd) begin rmem[rt[idx] * LN + idx] = rdat[idx]; ewr = 1; end
      if (WB) one = !vd;
      else begin rmem[a] = d; ewr = 1; end
      rv[idx] = 1; rd[idx] = WB; rt[idx] = tg; rdat[idx] = d; tag_s = "R8";
    end else begin
      rmem[a] = d; ewr = 1; tag_s = "R7";
    end

    @(negedge clk);
    wr0 = n_wr; rd0 = n_rd;
    req = 1'b1; we = st; addr = AW'(a); wdata = DW'(d);
    cyc = 1;
    forever begin
      #1;
      if (ready || cyc > 200) break;
      @(negedge clk);
      cyc++;
    end
    got = int'(rdata);
    @(posedge clk);
    #1 req = 1'b0;

    if (one) chk(cyc == 1, tag_s, cyc, 1);
    else     chk(cyc > 1, "R9", cyc, 2);
    if (!st) chk(got == edat, hit ? "R1" : "R11", got, edat);
    chk(n_wr - wr0 == ewr, tag_s, n_wr - wr0, ewr);
    chk(n_rd - rd0 == erd, tag_s, n_rd - rd0, erd);
    mism = 0;
    for (int i = 0; i < WORDS; i++) if (mem[i] != rmem[i]) mism++;
    chk(mism == 0, tag_s, mism, 0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    req = 0; we = 0; addr = '0; wdata = '0;
    for (int i = 0; i < LN; i++) begin rv[i] = 0; rd[i] = 0; rt[i] = 0; rdat[i] = 0; end
    for (int i = 0; i < WORDS; i++) rmem[i] = (i * 37 + 11) & 16'hffff;
    #12;
    chk(!mem_req && !ready, "R2", int'(mem_req), 0);
    wait (rst_n);
    // first access after reset must miss: R2
    begin
      int r0 = n_rd;
      access(0, 1, 0);
      chk(n_rd - r0 == 1, "R2", n_rd - r0, 1);
    end
    access(1, 1, 16'h1111);      // store hit
    access(0, 1, 0);             // load hit
    access(1, 9, 16'h2222);      // store miss on same line
    access(0, 1, 0);             // R7 occupant survives (no-alloc)
    access(0, 9, 0);             // R8 hit under allocate
    access(0, 17, 0);            // conflict load: possible eviction
    access(1, 25, 16'h3333);
    access(1, 33, 16'h4444);     // allocate onto modified line
    access(0, 25, 0);
    for (int n = 0; n < 200; n++) begin
      int a = $urandom_range(0, 2) * LN + $urandom_range(0, 3);
      access(1'($urandom_range(0, 1)), a, $urandom_range(0, 65535));
    end
    done = 1;
  end
endmodule

// File: tb/dm_cache_tb.sv
module dm_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int c0, c1, c2, c3, e0, e1, e2, e3;
  bit d0, d1, d2, d3;

  dm_cache_lane #(.WB(1'b1), .WA(1'b1)) u_l_wb_wa (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_err(e0), .done(d0));
  dm_cache_lane #(.WB(1'b1), .WA(1'b0)) u_l_wb_na (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_err(e1), .done(d1));
  dm_cache_lane #(.WB(1'b0), .WA(1'b1)) u_l_wt_wa (.clk(clk), .rst_n(rst_n), .n_chk(c2), .n_err(e2), .done(d2));
  dm_cache_lane #(.WB(1'b0), .WA(1'b0)) u_l_wt_na (.clk(clk), .rst_n(rst_n), .n_chk(c3), .n_err(e3), .done(d3));

  initial begin
    int wd_err;
    wd_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 150000; cyc++) begin
      @(negedge clk);
      if (d0 && d1 && d2 && d3) break;
    end
    if (!(d0 && d1 && d2 && d3)) begin
      wd_err = 1;
      $display("FAIL watchdog R9: actual done=%0d%0d%0d%0d expected 1111", d0, d1, d2, d3);
    end
    $display("Simulation finished: %0d checks, %0d errors",
             c0 + c1 + c2 + c3 + wd_err, e0 + e1 + e2 + e3 + wd_err);
    $finish;
  end
endmodule